// File: doc/BRIEF.md
# Multi-Rate Frequency Acquisition Sequencer

This block steers frequency acquisition for a clock-recovery loop that must handle several line rates. It runs on a slow system clock that has no relation to the line rate. Each acquisition cycle asks the oscillator to sweep upward for a fixed number of ticks. It then asks for a downward sweep of the same length, and after that it spends one idle tick. While the cycle runs, the block presents a 3-bit rate code. From that code it derives the divider modulus (1, 2, 4 or 8) and chooses between the low and the high oscillator centre curve.

In auto mode an internal counter owns the rate code and moves to the next code each time a cycle ends without lock. When the standard-select input is high the counter visits five codes. When it is low the counter visits three. Once lock is reported the code is held. If input data goes away, the code is frozen, so that acquisition resumes at the rate that last worked. In manual mode the code follows the external select inputs and does not change from one cycle to the next.

Top module: `acq_sequencer`

## Requirements
- R1: While reset is asserted the rate code is 000, the divider modulus is 4 and the high curve is selected. When reset is released with data present and no lock, the upward sweep request is active.
- R2: With standard-select high the code decodes as follows: 000 gives modulus 4 high, 001 gives 2 low, 010 gives 2 high, 011 gives 1 low, 100 gives 1 high, 101 gives 8 low and 110 gives 8 high. `div_mod` carries the modulus as the binary value 1, 2, 4 or 8.
- R3: With standard-select low the code decodes as follows: 000 and 001 give modulus 4, 010 and 011 give 2, 100 and 101 give 1, and 110 gives 8. The high curve is used for all of these.
- R4: `curve_low` is 1 exactly when standard-select is 1 and bit 0 of the rate code is 1.
- R5: In manual mode (`auto_mode`=0) `rate_code` takes the value of `sel_code` one clock later and keeps it across any number of acquisition cycles.
- R6: In manual mode a select value of 111 gives rate code 000.
- R7: An acquisition cycle lasts 2·SWEEP_TICKS+1 clocks. For SWEEP_TICKS clocks only `sweep_up` is high, for the next SWEEP_TICKS clocks only `sweep_dn` is high, and for one clock both are low.
- R8: In auto mode with standard-select high the code moves at the end of each cycle through 000, 001, 010, 011, 100 and then wraps back to 000.
- R9: In auto mode with standard-select low the code moves at the end of each cycle through 000, 010, 100 and back to 000. From code 001 it moves to 010, and from 011 it moves to 100.
- R10: While `lock_in` is high both sweep outputs are low and the rate code is held. After lock is released a fresh cycle begins with the upward sweep.
- R11: While `data_present` is low both sweep outputs are low and the rate code is frozen. When data returns, a fresh upward sweep begins at the frozen code.
- R12: In auto mode a code of 101, 110 or 111 is replaced by 000 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_mode | input | 1 | 1 = internal rate counter, 0 = external select |
| std_sel | input | 1 | Standard-select: 1 = five-rate set, 0 = three-rate set |
| sel_code | input | 3 | Manual rate select |
| lock_in | input | 1 | Loop reports phase lock |
| data_present | input | 1 | Input transitions are being detected |
| rate_code | output | 3 | Current rate code (rate indication) |
| div_mod | output | 4 | Divider modulus, value 1, 2, 4 or 8 |
| curve_low | output | 1 | 1 = low oscillator centre curve |
| sweep_up | output | 1 | Upward sweep request |
| sweep_dn | output | 1 | Downward sweep request |

## Verification
The assertions assume that `lock_in` and `data_present` are already synchronous to the system clock and change only between edges. They also assume that a change of `auto_mode` or `std_sel` is a deliberate reconfiguration, not a glitch. Under those assumptions a code change in auto mode can only follow the idle tick of a cycle. The stimulus drives every input on the falling edge and keeps each mode setting steady while a cycle count is being checked. Before any counting check it realigns the sweep timer, either through reset or through a one-clock lock pulse.

// File: rtl/acq_pkg.sv
package acq_pkg;
    localparam int CODE_W = 3;
    localparam int DIV_W  = 4;
    localparam logic [CODE_W-1:0] CODE_TOP_AUTO = 3'd4;
    localparam logic [CODE_W-1:0] CODE_VOID     = 3'd7;

    typedef enum logic [1:0] {
        PH_UP  = 2'd0,
        PH_DN  = 2'd1,
        PH_GAP = 2'd2
    } phase_t;
endpackage

// File: rtl/acq_rate_decode.sv
module acq_rate_decode
    import acq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              std_sel,
    input  logic [CODE_W-1:0] code,
    output logic [DIV_W-1:0]  div_mod,
    output logic              curve_low
);
    always_comb begin
        div_mod   = 4'd4;
        curve_low = 1'b0;
        if (std_sel) begin
            case (code)
                3'd1: begin div_mod = 4'd2; curve_low = 1'b1; end
                3'd2: begin div_mod = 4'd2; curve_low = 1'b0; end
                3'd3: begin div_mod = 4'd1; curve_low = 1'b1; end
                3'd4: begin div_mod = 4'd1; curve_low = 1'b0; end
                3'd5: begin div_mod = 4'd8; curve_low = 1'b1; end
                3'd6: begin div_mod = 4'd8; curve_low = 1'b0; end
                default: begin div_mod = 4'd4; curve_low = 1'b0; end
            endcase
        end else begin
            case (code)
                3'd2, 3'd3: div_mod = 4'd2;
                3'd4, 3'd5: div_mod = 4'd1;
                3'd6:       div_mod = 4'd8;
                default:    div_mod = 4'd4;
            endcase
        end
    end

    // The low curve is never combined with modulus 4.
    assert_low_not_div4_R4: assert property (@(posedge clk) disable iff (!rst_n)
        curve_low |-> (div_mod != 4'd4));
    assert_div_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(div_mod));
endmodule

// File: rtl/acq_rate_step.sv
module acq_rate_step
    import acq_pkg::*;
(
    input  logic              std_sel,
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] code_next
);
    always_comb begin
        if (std_sel) begin
            code_next = (code >= CODE_TOP_AUTO) ? '0 : code + 3'd1;
        end else if (code < 3'd2) begin
            code_next = 3'd2;
        end else if (code < 3'd4) begin
            code_next = 3'd4;
        end else begin
            code_next = '0;
        end
    end
endmodule

// File: rtl/acq_sweep_timer.sv
module acq_sweep_timer
    import acq_pkg::*;
#(
    parameter int SWEEP_TICKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sweep_up,
    output logic sweep_dn,
    output logic cycle_done
);
    localparam int TW = $clog2(SWEEP_TICKS + 1);
    localparam logic [TW-1:0] TICK_LAST = TW'(SWEEP_TICKS - 1);

    typedef struct packed {
        phase_t        phase;
        logic [TW-1:0] tick;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.phase = PH_UP;
            st_d.tick  = '0;
        end else begin
            case (st_q.phase)
                PH_UP: begin
                    if (st_q.tick == TICK_LAST) begin
                        st_d.phase = PH_DN;
                        st_d.tick  = '0;
                    end else begin
                        st_d.tick = st_q.tick + 1'b1;
                    end
                end
                PH_DN: begin
                    if (st_q.tick == TICK_LAST) begin
                        st_d.phase = PH_GAP;
                        st_d.tick  = '0;
                    end else begin
                        st_d.tick = st_q.tick + 1'b1;
                    end
                end
                default: begin
                    st_d.phase = PH_UP;
                    st_d.tick  = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_UP, tick: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sweep_up   = run && (st_q.phase == PH_UP);
    assign sweep_dn   = run && (st_q.phase == PH_DN);
    assign cycle_done = run && (st_q.phase == PH_GAP);

    // An idle tick is always followed by an upward sweep or a stop.
    assert_gap_then_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> (sweep_up || !run));
    assert_down_after_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_dn && $past(run)) |-> ($past(sweep_up) || $past(sweep_dn)));
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
    import acq_pkg::*;
#(
    parameter int SWEEP_TICKS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auto_mode,
    input  logic              std_sel,
    input  logic [CODE_W-1:0] sel_code,
    input  logic              lock_in,
    input  logic              data_present,
    output logic [CODE_W-1:0] rate_code,
    output logic [DIV_W-1:0]  div_mod,
    output logic              curve_low,
    output logic              sweep_up,
    output logic              sweep_dn
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
    } seq_t;

    seq_t seq_d, seq_q;
    logic run, cycle_done;
    logic [CODE_W-1:0] code_step;

    assign run = data_present && !lock_in;

    acq_sweep_timer #(.SWEEP_TICKS(SWEEP_TICKS)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .sweep_up  (sweep_up),
        .sweep_dn  (sweep_dn),
        .cycle_done(cycle_done)
    );

    acq_rate_step u_step (
        .std_sel  (std_sel),
        .code     (seq_q.code),
        .code_next(code_step)
    );

    always_comb begin
        seq_d = seq_q;
        if (!auto_mode) begin
            seq_d.code = (sel_code == CODE_VOID) ? '0 : sel_code;
        end else if (seq_q.code > CODE_TOP_AUTO) begin
            seq_d.code = '0;
        end else if (cycle_done) begin
            seq_d.code = code_step;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{code: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rate_code = seq_q.code;

    acq_rate_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .std_sel  (std_sel),
        .code     (seq_q.code),
        .div_mod  (div_mod),
        .curve_low(curve_low)
    );

    assert_lock_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && lock_in && seq_q.code <= CODE_TOP_AUTO) |=>
        (!auto_mode || seq_q.code == $past(seq_q.code)));
    assert_lock_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lock_in |-> !(sweep_up || sweep_dn));
    assert_nodata_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && !data_present && seq_q.code <= CODE_TOP_AUTO) |=>
        (!auto_mode || seq_q.code == $past(seq_q.code)));
    assert_void_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && seq_q.code > CODE_TOP_AUTO) |=> (!auto_mode || seq_q.code == '0));
    assert_step_at_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && $past(auto_mode) && $past(seq_q.code) <= CODE_TOP_AUTO &&
         seq_q.code != $past(seq_q.code)) |-> $past(cycle_done));
endmodule

// File: tb/sim_acq_sequencer.sv
module sim_acq_sequencer;
    localparam int TICKS = 4;
    localparam int CYC   = 2 * TICKS + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       auto_mode = 1'b0;
    logic       std_sel = 1'b1;
    logic [2:0] sel_code = 3'd0;
    logic       lock_in = 1'b0;
    logic       data_present = 1'b1;
    logic [2:0] rate_code;
    logic [3:0] div_mod;
    logic       curve_low, sweep_up, sweep_dn;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    acq_sequencer #(.SWEEP_TICKS(TICKS)) u0 (
        .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .std_sel(std_sel),
        .sel_code(sel_code), .lock_in(lock_in), .data_present(data_present),
        .rate_code(rate_code), .div_mod(div_mod), .curve_low(curve_low),
        .sweep_up(sweep_up), .sweep_dn(sweep_dn)
    );

    // {std_sel, sel_code, expected code, expected modulus, expected low curve}
    localparam logic [11:0] VEC [16] = '{
        {1'b0, 3'd0, 3'd0, 4'd4, 1'b0}, {1'b0, 3'd1, 3'd1, 4'd4, 1'b0},
        {1'b0, 3'd2, 3'd2, 4'd2, 1'b0}, {1'b0, 3'd3, 3'd3, 4'd2, 1'b0},
        {1'b0, 3'd4, 3'd4, 4'd1, 1'b0}, {1'b0, 3'd5, 3'd5, 4'd1, 1'b0},
        {1'b0, 3'd6, 3'd6, 4'd8, 1'b0}, {1'b0, 3'd7, 3'd0, 4'd4, 1'b0},
        {1'b1, 3'd0, 3'd0, 4'd4, 1'b0}, {1'b1, 3'd1, 3'd1, 4'd2, 1'b1},
        {1'b1, 3'd2, 3'd2, 4'd2, 1'b0}, {1'b1, 3'd3, 3'd3, 4'd1, 1'b1},
        {1'b1, 3'd4, 3'd4, 4'd1, 1'b0}, {1'b1, 3'd5, 3'd5, 4'd8, 1'b1},
        {1'b1, 3'd6, 3'd6, 4'd8, 1'b0}, {1'b1, 3'd7, 3'd0, 4'd4, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    // advance n rising edges, then settle just after the falling edge
    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic realign();
        lock_in = 1'b1;
        edges(1);
        lock_in = 1'b0;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        edges(2);
        chk_eq("R1 code", int'(rate_code), 0);
        chk_eq("R1 div", int'(div_mod), 4);
        chk_eq("R1 low", int'(curve_low), 0);

        rst_n = 1'b1;
        lock_in = 1'b1;
        // R2 R3 R4 R5 R6: manual decode table
        for (int i = 0; i < 16; i++) begin
            logic [11:0] v;
            v = VEC[i];
            std_sel = v[11];
            sel_code = v[10:8];
            edges(1);
            chk_eq(v[11] ? "R2/R5/R6 code" : "R3/R5/R6 code", int'(rate_code), int'(v[7:5]));
            chk_eq(v[11] ? "R2 div" : "R3 div", int'(div_mod), int'(v[4:1]));
            chk_eq("R4 curve", int'(curve_low), int'(v[0]));
        end
        lock_in = 1'b0;

        // R5: manual code fixed across cycles
        std_sel = 1'b1;
        sel_code = 3'd2;
        edges(3 * CYC);
        chk_eq("R5 manual hold", int'(rate_code), 2);

        // R1 R7 R8: auto sequencing from reset
        rst_n = 1'b0;
        auto_mode = 1'b1;
        edges(2);
        rst_n = 1'b1;
        #1;
        chk_eq("R1 sweep_up after reset", int'(sweep_up), 1);
        for (int k = 1; k <= 30; k++) begin
            edges(1);
            chk_eq("R8 auto code", int'(rate_code), (k / CYC) % 5);
            chk_eq("R7 sweep_up", int'(sweep_up), ((k % CYC) < TICKS) ? 1 : 0);
            chk_eq("R7 sweep_dn", int'(sweep_dn),
                   ((k % CYC) >= TICKS && (k % CYC) < 2 * TICKS) ? 1 : 0);
        end

        // R10: lock holds code 3 and idles sweeps
        lock_in = 1'b1;
        #1;
        chk_eq("R10 sweeps idle", int'(sweep_up) + int'(sweep_dn), 0);
        edges(3 * CYC);
        chk_eq("R10 code held", int'(rate_code), 3);
        chk_eq("R10 sweeps idle late", int'(sweep_up) + int'(sweep_dn), 0);
        lock_in = 1'b0;
        #1;
        chk_eq("R10 restart up", int'(sweep_up), 1);
        edges(CYC - 1);
        chk_eq("R10 no early step", int'(rate_code), 3);
        edges(1);
        chk_eq("R8 step to 4", int'(rate_code), 4);

        // R11: data loss freezes code 4
        edges(2);
        data_present = 1'b0;
        #1;
        chk_eq("R11 sweeps idle", int'(sweep_up) + int'(sweep_dn), 0);
        edges(3 * CYC);
        chk_eq("R11 code frozen", int'(rate_code), 4);
        data_present = 1'b1;
        #1;
        chk_eq("R11 resume up", int'(sweep_up), 1);
        edges(CYC);
        chk_eq("R8 wrap to 0", int'(rate_code), 0);

        // R9: reduced set order
        std_sel = 1'b0;
        edges(CYC);
        chk_eq("R9 step 0->2", int'(rate_code), 2);
        edges(CYC);
        chk_eq("R9 step 2->4", int'(rate_code), 4);
        edges(CYC);
        chk_eq("R9 wrap 4->0", int'(rate_code), 0);

        // R9: odd code moves to the next even one
        auto_mode = 1'b0;
        sel_code = 3'd3;
        edges(1);
        auto_mode = 1'b1;
        realign();
        edges(CYC - 1);
        chk_eq("R9 odd hold", int'(rate_code), 3);
        edges(1);
        chk_eq("R9 3->4", int'(rate_code), 4);

        // R12: void codes in auto mode
        auto_mode = 1'b0;
        std_sel = 1'b1;
        sel_code = 3'd5;
        edges(1);
        chk_eq("R5 load 5", int'(rate_code), 5);
        auto_mode = 1'b1;
        edges(1);
        chk_eq("R12 5->0", int'(rate_code), 0);
        auto_mode = 1'b0;
        std_sel = 1'b0;
        sel_code = 3'd6;
        edges(1);
        auto_mode = 1'b1;
        edges(1);
        chk_eq("R12 6->0", int'(rate_code), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule